// File: doc/BRIEF.md
# Burst-Inhibited Cache Line Write Sequencer

This block is a bus master that writes one 16-byte cache line to a target that cannot take a true burst. It moves the line as four separate long-word data phases on a 32-bit synchronous bus. Each phase ends with its own transfer acknowledge from the target. A line request carries a line address, four data words and a locked flag. The request is taken only while the sequencer is idle. It then runs the whole line without further help from the requester.

Every data phase has one setup clock followed by at least one acknowledge clock. The acknowledge input counts only in an acknowledge clock. While it is low, the phase stretches with wait states. The transfer-start strobe marks only the first setup clock. The address, size code and current data word stay steady while a phase waits. The long-word index in address bits 3..2 starts at zero. It steps only when the target raises the count-advance input. After the fourth acknowledge, the sequencer floats the data bus, drops the in-progress and lock outputs, and returns to idle.

Top module: `blw_line_writer`

## Requirements
- R1: A line request (`req_valid_i` high) is taken only on a clock where `busy_o` is low. A request seen while busy changes no output and starts no line. `busy_o` rises in the clock that shows the start strobe and falls in the clock after the fourth acknowledge is sampled.
- R2: `ts_o` is high for exactly one clock, which is the first clock of a line. It is low in every later clock of that line.
- R3: While a line runs, `addr_o[31:4]` equals `req_addr_i[31:4]` of the taken request and `addr_o[1:0]` is 00. `addr_o[3:2]` is 00 in the first clock. `addr_o` changes only after a clock in which `cla_i` was sampled high. `siz_o` reads 2'b00, the long-word code.
- R4: During data phase k (k = 0..3), `data_o` carries `req_data_i[32*k+31 : 32*k]` and `data_oe_o` is high. The word does not change while the phase waits.
- R5: Each phase is one setup clock plus acknowledge clocks. `ack_i` high in a setup clock is ignored. `ack_i` low in an acknowledge clock adds one wait state and keeps the same phase.
- R6: Each clock of a running line in which `cla_i` is sampled high raises `addr_o[3:2]` by one, wrapping from 11 to 00. `cla_i` has no effect while idle.
- R7: With no wait states, `tip_o` stays high for exactly 8 clocks. Each wait state adds one clock.
- R8: In the clock after the fourth acknowledge, `tip_o`, `data_oe_o`, `lock_o` and `lock_end_o` are low.
- R9: For a locked request, `lock_o` is high throughout the line. `lock_end_o` is high only during the fourth data phase. For an unlocked request both stay low.
- R10: A low `rst_n` puts the sequencer into idle at once, with `ts_o`, `tip_o`, `busy_o`, `data_oe_o`, `lock_o` and `lock_end_o` low. The release of reset takes effect two clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Line write request |
| req_addr_i | input | 32 | Byte address of the line |
| req_data_i | input | 128 | Four long words, word 0 in the low bits |
| req_lock_i | input | 1 | Run the line as a locked transfer |
| busy_o | output | 1 | A line is in progress |
| ack_i | input | 1 | Transfer acknowledge from the target |
| cla_i | input | 1 | Target request to step address bits 3..2 |
| addr_o | output | 32 | Bus address |
| siz_o | output | 2 | Transfer size code, 00 = long word |
| ts_o | output | 1 | Transfer start strobe |
| tip_o | output | 1 | Transfer in progress |
| lock_o | output | 1 | Locked transfer |
| lock_end_o | output | 1 | Last phase of a locked transfer |
| data_o | output | 32 | Write data |
| data_oe_o | output | 1 | Data bus drive enable, low = three-stated |

## Verification
The bench builds the sequencer with its defaults: 32-bit address and data and four phases per line. With these values the two-bit long-word index can wrap inside a single line by holding `cla_i` high through all eight clocks, and the two-bit wait fields in the stimulus table reach three wait states per phase. With four phases, only a short table is needed to reach a locked line whose final phase waits, and a request that arrives mid-line while the bus is held.

// File: rtl/blw_pkg.sv
package blw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_SETUP = 2'b01,
    ST_ACK   = 2'b10
  } blw_phase_e;

  localparam logic [1:0] SIZ_LONG = 2'b00;

endpackage

// File: rtl/blw_rst_sync.sv
module blw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);

  logic [1:0] sync_q;

  // assertion is immediate, release is aligned to clk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ni = sync_q[1];

endmodule

// File: rtl/blw_seq.sv
module blw_seq
  import blw_pkg::*;
#(
  parameter int BEATS  = 4,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ack_i,
  output blw_phase_e        phase_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              last_o
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  blw_phase_e        phase_q, phase_d;
  logic [BEAT_W-1:0] beat_q,  beat_d;
  logic              phase_en, beat_en;
  logic              is_last;

  assign is_last = (beat_q == LAST_BEAT);

  // next-state logic
  always_comb begin
    phase_d  = phase_q;
    beat_d   = beat_q;
    phase_en = 1'b0;
    beat_en  = 1'b0;
    unique case (phase_q)
      ST_IDLE: begin
        if (start_i) begin
          phase_d  = ST_SETUP;
          phase_en = 1'b1;
          beat_d   = '0;
          beat_en  = 1'b1;
        end
      end
      ST_SETUP: begin
        phase_d  = ST_ACK;
        phase_en = 1'b1;
      end
      ST_ACK: begin
        if (ack_i) begin
          phase_en = 1'b1;
          if (is_last) begin
            phase_d = ST_IDLE;
          end else begin
            phase_d = ST_SETUP;
            beat_d  = beat_q + 1'b1;
            beat_en = 1'b1;
          end
        end
      end
      default: begin
        phase_d  = ST_IDLE;
        phase_en = 1'b1;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= ST_IDLE;
    end else if (phase_en) begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
    end else if (beat_en) begin
      beat_q <= beat_d;
    end
  end

  assign phase_o = phase_q;
  assign beat_o  = beat_q;
  assign last_o  = is_last;

endmodule

// File: rtl/blw_addr_step.sv
module blw_addr_step #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2,
  parameter int BEAT_W = 2,
  localparam int LINE_W = ADDR_W - OFF_W - BEAT_W
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] line_addr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [LINE_W-1:0] line_q, line_d;
  logic [BEAT_W-1:0] word_q, word_d;
  logic              line_en, word_en;

  always_comb begin
    line_d  = line_addr_i[ADDR_W-1 -: LINE_W];
    line_en = load_i;
    word_en = load_i | step_i;
    if (load_i) word_d = '0;
    else        word_d = word_q + 1'b1;   // wraps at the line boundary
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
    end else if (line_en) begin
      line_q <= line_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  assign addr_o = {line_q, word_q, {OFF_W{1'b0}}};

endmodule

// File: rtl/blw_data_sel.sv
module blw_data_sel #(
  parameter int DATA_W = 32,
  parameter int BEATS  = 4,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [BEATS*DATA_W-1:0] words_i,
  input  logic [BEAT_W-1:0]       sel_i,
  output logic [DATA_W-1:0]       word_o
);

  logic [DATA_W-1:0] word_q [BEATS];

  for (genvar g = 0; g < BEATS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q[g] <= '0;
      end else if (load_i) begin
        word_q[g] <= words_i[g*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    word_o = word_q[0];
    for (int i = 0; i < BEATS; i++) begin
      if (sel_i == BEAT_W'(i)) word_o = word_q[i];
    end
  end

endmodule

// File: rtl/blw_line_writer.sv
module blw_line_writer
  import blw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int OFF_W  = $clog2(DATA_W / 8)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [BEATS*DATA_W-1:0] req_data_i,
  input  logic                    req_lock_i,
  output logic                    busy_o,
  input  logic                    ack_i,
  input  logic                    cla_i,
  output logic [ADDR_W-1:0]       addr_o,
  output logic [1:0]              siz_o,
  output logic                    ts_o,
  output logic                    tip_o,
  output logic                    lock_o,
  output logic                    lock_end_o,
  output logic [DATA_W-1:0]       data_o,
  output logic                    data_oe_o
);

  logic              rst_ni;
  blw_phase_e        phase;
  logic [BEAT_W-1:0] beat;
  logic              last_beat;
  logic              running;
  logic              take;
  logic              step;
  logic              lock_q;
  logic [DATA_W-1:0] cur_word;

  blw_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  assign running = (phase != ST_IDLE);
  assign take    = req_valid_i & ~running;
  assign step    = running & cla_i;

  blw_seq #(.BEATS(BEATS)) u_seq (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .start_i (take),
    .ack_i   (ack_i),
    .phase_o (phase),
    .beat_o  (beat),
    .last_o  (last_beat)
  );

  blw_addr_step #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .BEAT_W (BEAT_W)
  ) u_addr (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .load_i      (take),
    .line_addr_i (req_addr_i),
    .step_i      (step),
    .addr_o      (addr_o)
  );

  blw_data_sel #(
    .DATA_W (DATA_W),
    .BEATS  (BEATS)
  ) u_data (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .load_i  (take),
    .words_i (req_data_i),
    .sel_i   (beat),
    .word_o  (cur_word)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
    end else if (take) begin
      lock_q <= req_lock_i;
    end
  end

  assign busy_o     = running;
  assign tip_o      = running;
  assign ts_o       = (phase == ST_SETUP) && (beat == '0);
  assign siz_o      = SIZ_LONG;
  assign data_oe_o  = running;
  assign data_o     = running ? cur_word : '0;
  assign lock_o     = running & lock_q;
  assign lock_end_o = running & lock_q & last_beat;

endmodule

// File: rtl/blw_line_writer_chk.sv
module blw_line_writer_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              ack_i,
  input logic              cla_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              ts_o,
  input logic              tip_o,
  input logic              lock_o,
  input logic              lock_end_o,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o
);

  // R1: a running line cannot end without an acknowledge
  p_busy_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !ack_i |=> busy_o);

  // R2: the start strobe lasts one clock
  p_ts_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ts_o |=> !ts_o);

  // R2: every line opens with the start strobe
  p_ts_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tip_o) |-> ts_o);

  // R3: address steady unless the target asked for a step
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tip_o && $past(tip_o) && !$past(cla_i) |-> $stable(addr_o));

  // R4: data steady across a clock without acknowledge
  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tip_o && $past(tip_o) && !$past(ack_i) |-> $stable(data_o));

  // R6: a sampled count-advance moves the long-word index by one
  p_cla_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tip_o && $past(tip_o) && $past(cla_i) |->
      addr_o[OFF_W +: BEAT_W] == BEAT_W'($past(addr_o[OFF_W +: BEAT_W]) + 1'b1));

  // R8: bus released when no line is running
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tip_o |-> !data_oe_o && !lock_o && !lock_end_o);

  // R9: the last-locked marker only appears inside a locked line
  p_lock_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_end_o |-> lock_o);

endmodule

bind blw_line_writer blw_line_writer_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .OFF_W  (OFF_W),
  .BEAT_W (BEAT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_o     (busy_o),
  .ack_i      (ack_i),
  .cla_i      (cla_i),
  .addr_o     (addr_o),
  .ts_o       (ts_o),
  .tip_o      (tip_o),
  .lock_o     (lock_o),
  .lock_end_o (lock_end_o),
  .data_o     (data_o),
  .data_oe_o  (data_oe_o)
);

// File: tb/blw_line_writer_tb.sv
module blw_line_writer_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid_i;
  logic [31:0]  req_addr_i;
  logic [127:0] req_data_i;
  logic         req_lock_i;
  logic         busy_o;
  logic         ack_i;
  logic         cla_i;
  logic [31:0]  addr_o;
  logic [1:0]   siz_o;
  logic         ts_o;
  logic         tip_o;
  logic         lock_o;
  logic         lock_end_o;
  logic [31:0]  data_o;
  logic         data_oe_o;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  blw_line_writer u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .req_data_i  (req_data_i),
    .req_lock_i  (req_lock_i),
    .busy_o      (busy_o),
    .ack_i       (ack_i),
    .cla_i       (cla_i),
    .addr_o      (addr_o),
    .siz_o       (siz_o),
    .ts_o        (ts_o),
    .tip_o       (tip_o),
    .lock_o      (lock_o),
    .lock_end_o  (lock_end_o),
    .data_o      (data_o),
    .data_oe_o   (data_oe_o)
  );

  // {lock, cla mask for phases 2..0, waits w3 w2 w1 w0, cla held, poke while busy}
  localparam logic [13:0] VEC [8] = '{
    {1'b0, 3'b111, 8'b00_00_00_00, 1'b0, 1'b0},
    {1'b1, 3'b000, 8'b00_00_00_00, 1'b0, 1'b0},
    {1'b0, 3'b101, 8'b01_00_10_11, 1'b0, 1'b0},
    {1'b1, 3'b010, 8'b11_11_11_11, 1'b0, 1'b0},
    {1'b0, 3'b000, 8'b00_00_00_00, 1'b1, 1'b0},
    {1'b0, 3'b011, 8'b00_01_00_01, 1'b0, 1'b1},
    {1'b1, 3'b111, 8'b10_00_00_10, 1'b0, 1'b1},
    {1'b0, 3'b100, 8'b00_11_00_00, 1'b1, 1'b0}
  };

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk("R8", {tag, " tip"},      64'(tip_o),      64'd0);
    chk("R1", {tag, " busy"},     64'(busy_o),     64'd0);
    chk("R8", {tag, " data_oe"},  64'(data_oe_o),  64'd0);
    chk("R8", {tag, " lock"},     64'(lock_o),     64'd0);
    chk("R8", {tag, " lock_end"}, 64'(lock_end_o), 64'd0);
    chk("R2", {tag, " ts"},       64'(ts_o),       64'd0);
  endtask

  task automatic run_line(input int idx, input logic [13:0] v);
    logic [31:0]  base;
    logic [31:0]  w [4];
    logic [1:0]   lw;
    logic         lock, cla_all, poke, cla_now;
    int           cycles, total_wait, nw;
    base    = 32'h1234_5670 + (32'(idx) << 8) + 32'h0000_000E;
    lock    = v[13];
    cla_all = v[1];
    poke    = v[0];
    for (int k = 0; k < 4; k++) w[k] = 32'hA000_0000 + 32'(idx * 16 + k) * 32'h0101_0101;
    total_wait = 0;
    for (int k = 0; k < 4; k++) total_wait += int'(v[2 + 2*k +: 2]);

    @(negedge clk);
    chk("R1", "idle before request", 64'(busy_o), 64'd0);
    req_valid_i = 1'b1;
    req_addr_i  = base;
    req_data_i  = {w[3], w[2], w[1], w[0]};
    req_lock_i  = lock;
    ack_i = 1'b0;
    cla_i = 1'b0;
    @(negedge clk);
    lw = 2'b00;
    cycles = 0;
    for (int b = 0; b < 4; b++) begin
      nw = int'(v[2 + 2*b +: 2]);
      // setup clock of phase b
      chk("R2", "ts in setup", 64'(ts_o), (b == 0) ? 64'd1 : 64'd0);
      chk("R1", "busy", 64'(busy_o), 64'd1);
      chk("R7", "tip", 64'(tip_o), 64'd1);
      chk("R4", "data", 64'(data_o), 64'(w[b]));
      chk("R4", "data_oe", 64'(data_oe_o), 64'd1);
      chk("R3", "addr", 64'(addr_o), 64'({base[31:4], lw, 2'b00}));
      chk("R3", "siz long", 64'(siz_o), 64'd0);
      chk("R9", "lock", 64'(lock_o), 64'(lock));
      chk("R9", "lock_end", 64'(lock_end_o), 64'(lock && b == 3));
      if (poke) begin
        req_valid_i = 1'b1;
        req_addr_i  = 32'hFFFF_FFF0;
        req_data_i  = '1;
        req_lock_i  = ~lock;
      end else begin
        req_valid_i = 1'b0;
      end
      ack_i = 1'b1;                    // R5: must be ignored in a setup clock
      cla_i = cla_all;
      @(negedge clk);
      cycles++;
      if (cla_all) lw = lw + 2'd1;
      for (int k = 0; k <= nw; k++) begin
        chk("R5", "ts in ack clock", 64'(ts_o), 64'd0);
        chk("R5", "data held", 64'(data_o), 64'(w[b]));
        chk("R1", "busy in ack clock", 64'(busy_o), 64'd1);
        chk("R3", "addr held", 64'(addr_o), 64'({base[31:4], lw, 2'b00}));
        chk("R9", "lock_end in ack", 64'(lock_end_o), 64'(lock && b == 3));
        ack_i   = (k == nw);
        cla_now = cla_all | ((k == nw) && (b < 3) && v[10 + b]);
        cla_i   = cla_now;
        if (b == 3 && k == nw) req_valid_i = 1'b0;
        @(negedge clk);
        cycles++;
        if (cla_now) lw = lw + 2'd1;
      end
    end
    ack_i = 1'b0;
    req_valid_i = 1'b0;
    chk_idle("after line");
    chk("R7", "line length", 64'(cycles), 64'(8 + total_wait));
    // R6: count-advance has no effect while idle
    cla_i = 1'b1;
    @(negedge clk);
    chk("R6", "cla ignored idle", 64'(addr_o), 64'({base[31:4], lw, 2'b00}));
    chk("R1", "no restart after poke", 64'(busy_o), 64'd0);
    cla_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid_i = 1'b0;
    req_addr_i  = '0;
    req_data_i  = '0;
    req_lock_i  = 1'b0;
    ack_i = 1'b0;
    cla_i = 1'b0;
    repeat (3) @(negedge clk);
    chk_idle("R10 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle("R10 after release");

    for (int i = 0; i < 8; i++) run_line(i, VEC[i]);

    // R10: reset in the middle of a line
    @(negedge clk);
    req_valid_i = 1'b1;
    req_addr_i  = 32'h0BAD_0000;
    req_data_i  = {4{32'h5555_AAAA}};
    req_lock_i  = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    @(negedge clk);
    chk("R10", "line running", 64'(tip_o), 64'd1);
    rst_n = 1'b0;
    #1;
    chk("R10", "tip on reset", 64'(tip_o), 64'd0);
    chk("R10", "oe on reset", 64'(data_oe_o), 64'd0);
    chk("R10", "lock on reset", 64'(lock_o), 64'd0);
    chk("R10", "busy on reset", 64'(busy_o), 64'd0);
    chk("R10", "ts on reset", 64'(ts_o), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle("R10 recovered");
    run_line(9, {1'b1, 3'b111, 8'b00_01_00_00, 1'b0, 1'b0});

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule